// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular list of 8-byte transmit descriptors held in system memory. On a kick for a chosen ring it fetches the descriptor at that ring's current pointer. For each ready descriptor it reads the referenced payload bytes and gathers the bytes of one or more descriptors into a frame. The frame leaves on an 8-bit byte stream, with a marker on its final byte. After each descriptor the block writes the flags field back with its status bits cleared, raises an event pulse when the descriptor asks for one, and moves to the next descriptor or wraps to the ring base.

The walk ends at the first descriptor that is not ready. The block then reports that descriptor's address, so it can be saved as the ring's new pointer, and sets a per-ring halt bit. A frame that has not reached its last descriptor when the walk halts stays open and continues on the next walk. Short frames can be zero-padded to a minimum length. Memory traffic goes through a single byte-wide request/response port with one request outstanding at a time.

Top module: `txring_walker`

## Requirements
- R1: While `cfg_tx_en` is low, a kick starts no walk: no memory request, no pointer report and no event follow.
- R2: A descriptor is bytes 0..7 at its address: a 16-bit flags field at bytes 0-1, a 16-bit length at bytes 2-3 and a 32-bit buffer address at bytes 4-7. With `cfg_le` low each field is most-significant byte first; with it high, least-significant byte first. Flag bits: 15 ready, 14 pad, 13 wrap, 12 interrupt, 11 last; bits 10, 8 and the rest are kept as they are.
- R3: Bits [2:0] of the ring base and of the ring pointer are ignored, and every memory request carries `cfg_addr_hi` as address bits [35:32].
- R4: The walk stops at the first descriptor with ready clear. It then pulses `ptr_upd_valid` with that descriptor's address and ring, and sets `halt_status` bit (31 - ring). A new walk on that ring clears the bit.
- R5: A descriptor with length zero adds no bytes. A non-zero length adds that many bytes, read from the buffer address upward, to the open frame.
- R6: When a descriptor with the last flag completes and the open frame holds at least one byte, the frame's bytes leave in order and the final byte carries `tx_last`. A frame may span several descriptors and several walks.
- R7: If the pad flag of the frame's first descriptor with non-zero length is set, or `cfg_pad_en` is high, a frame shorter than MIN_LEN (64) bytes is extended with zero bytes to exactly MIN_LEN. The pad flags of later descriptors have no effect.
- R8: A descriptor with the interrupt flag pulses `ev_frame` if it ended a non-empty frame and `ev_buf` otherwise. The two pulses never occur together.
- R9: Only the flags field is written back, to bytes 0-1 in the selected order. Bits 15, 9, 7, 6, 5:2, 1 and 0 are cleared and the other bits keep their values. Both writes are accepted before the next descriptor is fetched.
- R10: After a ready descriptor, the pointer goes to the ring base if the wrap flag is set and otherwise advances by 8.
- R11: A memory request that is not accepted keeps its valid, address, write flag and data unchanged until it is accepted.
- R12: A stream byte that is not accepted keeps its data and last marker unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Transmit enable; a kick is ignored while low |
| cfg_le | input | 1 | Descriptor byte order: 1 least-significant first |
| cfg_pad_en | input | 1 | Global short-frame padding enable |
| cfg_addr_hi | input | HI_W | Address bits above 32 for all requests |
| ring_base | input | NRINGS*32 | Per-ring base addresses, ring 0 in the low word |
| ring_ptr | input | NRINGS*32 | Per-ring current descriptor pointers |
| kick | input | 1 | Start a walk (taken when not busy) |
| kick_ring | input | RW | Ring to walk |
| busy | output | 1 | A walk is in progress |
| ptr_upd_valid | output | 1 | Pulse: walk stopped, pointer to save |
| ptr_upd_ring | output | RW | Ring of the saved pointer |
| ptr_upd_addr | output | 32 | Address of the descriptor that was not ready |
| halt_status | output | 32 | Halt bits, bit 31-r for ring r |
| ev_frame | output | 1 | Pulse: frame-done event |
| ev_buf | output | 1 | Pulse: buffer-done event |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32+HI_W | Byte address |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |

## Verification
The checks assume the memory side returns exactly one response for each accepted read, at least one cycle after acceptance and in request order, and no response for writes. They also assume the configuration inputs stay constant during a walk and that every ring holds a descriptor that is not ready, so each walk ends. The bench memory model answers every accepted read one cycle later and gives none for writes. It drops its request-ready and the stream-ready on fixed cycle patterns to exercise both hold rules. The bench changes configuration and descriptors only while the block is idle, and always leaves a cleared descriptor after the ones it prepares.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int FB_RDY  = 15;
  localparam int FB_PAD  = 14;
  localparam int FB_WRAP = 13;
  localparam int FB_INT  = 12;
  localparam int FB_LAST = 11;
  // status bits cleared on write-back: ready, defer, late coll., retry limit, retry count, underrun, truncation
  localparam logic [15:0] WB_CLEAR = 16'h82FF;

  typedef enum logic [3:0] {
    S_IDLE, S_DRD, S_DEC, S_PAY, S_EMIT, S_FIN, S_PAD, S_FLUSH, S_WB0, S_WB1
  } txr_state_e;
endpackage

// File: rtl/txr_bd_fields.sv
module txr_bd_fields
  import txr_pkg::*;
(
  input  logic [63:0] raw,
  input  logic        le,
  output logic [15:0] flags,
  output logic [15:0] len,
  output logic [31:0] bptr,
  output logic [7:0]  wb_b0,
  output logic [7:0]  wb_b1
);
  logic [15:0] keep;

  always_comb begin
    if (le) begin
      flags = raw[15:0];
      len   = raw[31:16];
      bptr  = raw[63:32];
    end else begin
      flags = {raw[7:0], raw[15:8]};
      len   = {raw[23:16], raw[31:24]};
      bptr  = {raw[39:32], raw[47:40], raw[55:48], raw[63:56]};
    end
    keep  = flags & ~WB_CLEAR;
    wb_b0 = le ? keep[7:0]  : keep[15:8];
    wb_b1 = le ? keep[15:8] : keep[7:0];
  end
endmodule

// File: rtl/txr_byte_stage.sv
module txr_byte_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_v,
  input  logic [DW-1:0] push_b,
  input  logic          flush_v,
  output logic          accept,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready
);
  logic          hold_v;
  logic [DW-1:0] hold_b;
  logic          slot_free;

  assign slot_free = !out_valid || out_ready;

  always_comb begin
    if (flush_v) accept = slot_free;
    else         accept = push_v && (!hold_v || slot_free);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_b    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (flush_v && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= hold_b;
        out_last  <= 1'b1;
        hold_v    <= 1'b0;
      end else if (push_v && accept) begin
        if (hold_v) begin
          out_valid <= 1'b1;
          out_data  <= hold_b;
          out_last  <= 1'b0;
        end
        hold_b <= push_b;
        hold_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txr_pkg::*;
#(
  parameter int NRINGS  = 2,
  parameter int HI_W    = 4,
  parameter int FLEN_W  = 16,
  parameter int MIN_LEN = 64,
  localparam int RW = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_tx_en,
  input  logic                 cfg_le,
  input  logic                 cfg_pad_en,
  input  logic [HI_W-1:0]      cfg_addr_hi,
  input  logic [NRINGS*32-1:0] ring_base,
  input  logic [NRINGS*32-1:0] ring_ptr,
  input  logic                 kick,
  input  logic [RW-1:0]        kick_ring,
  output logic                 busy,
  output logic                 ptr_upd_valid,
  output logic [RW-1:0]        ptr_upd_ring,
  output logic [31:0]          ptr_upd_addr,
  output logic [31:0]          halt_status,
  output logic                 ev_frame,
  output logic                 ev_buf,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [31+HI_W:0]     mem_req_addr,
  output logic [7:0]           mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [7:0]           mem_rsp_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_data,
  output logic                 tx_last
);
  localparam logic [FLEN_W-1:0] MIN_F = FLEN_W'(MIN_LEN);

  txr_state_e       st;
  logic             wt;
  logic [RW-1:0]    ring;
  logic [31:0]      base, cur;
  logic [63:0]      raw;
  logic [2:0]       bidx;
  logic [15:0]      cnt;
  logic [FLEN_W-1:0] flen;
  logic             pad_opt;
  logic [7:0]       nb;

  logic [15:0] d_flags, d_len;
  logic [31:0] d_bptr;
  logic [7:0]  wb_b0, wb_b1;
  logic        push_v, flush_v, push_ok;
  logic [7:0]  push_b;

  txr_bd_fields u_fields (
    .raw(raw), .le(cfg_le), .flags(d_flags), .len(d_len), .bptr(d_bptr),
    .wb_b0(wb_b0), .wb_b1(wb_b1)
  );

  assign push_v  = (st == S_EMIT) || (st == S_PAD);
  assign push_b  = (st == S_PAD) ? 8'h00 : nb;
  assign flush_v = (st == S_FLUSH);

  txr_byte_stage #(.DW(8)) u_stage (
    .clk(clk), .rst(rst), .push_v(push_v), .push_b(push_b), .flush_v(flush_v),
    .accept(push_ok), .out_valid(tx_valid), .out_data(tx_data),
    .out_last(tx_last), .out_ready(tx_ready)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;       wt <= 1'b0;
      mem_req_valid <= 1'b0; mem_req_we <= 1'b0;
      mem_req_addr <= '0;    mem_req_wdata <= '0;
      ring <= '0; base <= '0; cur <= '0; raw <= '0; bidx <= '0;
      cnt <= '0; flen <= '0; pad_opt <= 1'b0; nb <= '0;
      halt_status <= '0; ptr_upd_valid <= 1'b0; ptr_upd_ring <= '0;
      ptr_upd_addr <= '0; ev_frame <= 1'b0; ev_buf <= 1'b0;
    end else begin
      ptr_upd_valid <= 1'b0;
      ev_frame      <= 1'b0;
      ev_buf        <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
        wt            <= !mem_req_we;
      end
      if (wt && mem_rsp_valid) wt <= 1'b0;

      case (st)
        S_IDLE: if (kick && cfg_tx_en) begin
          ring <= kick_ring;
          base <= ring_base[32*int'(kick_ring) +: 32] & ~32'h7;
          cur  <= ring_ptr[32*int'(kick_ring) +: 32] & ~32'h7;
          halt_status[31 - int'(kick_ring)] <= 1'b0;
          bidx <= '0;
          st   <= S_DRD;
        end
        S_DRD: begin
          if (!mem_req_valid && !wt) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= {cfg_addr_hi, cur + 32'(bidx)};
          end
          if (wt && mem_rsp_valid) begin
            raw[8*bidx +: 8] <= mem_rsp_data;
            bidx <= bidx + 3'd1;
            if (bidx == 3'd7) st <= S_DEC;
          end
        end
        S_DEC: begin
          if (!d_flags[FB_RDY]) begin
            ptr_upd_valid <= 1'b1;
            ptr_upd_ring  <= ring;
            ptr_upd_addr  <= cur;
            halt_status[31 - int'(ring)] <= 1'b1;
            st <= S_IDLE;
          end else begin
            if (d_len != 16'd0 && flen == '0) pad_opt <= d_flags[FB_PAD];
            cnt <= '0;
            st  <= (d_len != 16'd0) ? S_PAY : S_FIN;
          end
        end
        S_PAY: begin
          if (!mem_req_valid && !wt) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= {cfg_addr_hi, d_bptr + 32'(cnt)};
          end
          if (wt && mem_rsp_valid) begin
            nb <= mem_rsp_data;
            st <= S_EMIT;
          end
        end
        S_EMIT: if (push_ok) begin
          cnt  <= cnt + 16'd1;
          flen <= flen + FLEN_W'(1);
          st   <= (cnt + 16'd1 == d_len) ? S_FIN : S_PAY;
        end
        S_FIN: begin
          if (d_flags[FB_LAST] && flen != '0) begin
            st <= ((pad_opt || cfg_pad_en) && flen < MIN_F) ? S_PAD : S_FLUSH;
          end else begin
            ev_buf <= d_flags[FB_INT];
            st     <= S_WB0;
          end
        end
        S_PAD: if (push_ok) begin
          flen <= flen + FLEN_W'(1);
          if (flen + FLEN_W'(1) == MIN_F) st <= S_FLUSH;
        end
        S_FLUSH: if (push_ok) begin
          flen     <= '0;
          pad_opt  <= 1'b0;
          ev_frame <= d_flags[FB_INT];
          st       <= S_WB0;
        end
        S_WB0: begin
          if (!mem_req_valid) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b1;
            mem_req_addr  <= {cfg_addr_hi, cur};
            mem_req_wdata <= wb_b0;
          end else if (mem_req_ready) st <= S_WB1;
        end
        S_WB1: begin
          if (!mem_req_valid) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b1;
            mem_req_addr  <= {cfg_addr_hi, cur + 32'd1};
            mem_req_wdata <= wb_b1;
          end else if (mem_req_ready) begin
            cur  <= d_flags[FB_WRAP] ? base : cur + 32'd8;
            bidx <= '0;
            st   <= S_DRD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_walker_chk.sv
module txring_walker_chk #(
  parameter int NRINGS = 2,
  parameter int HI_W   = 4,
  localparam int RW = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              ptr_upd_valid,
  input logic [RW-1:0]     ptr_upd_ring,
  input logic [31:0]       ptr_upd_addr,
  input logic [31:0]       halt_status,
  input logic              ev_frame,
  input logic              ev_buf,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [31+HI_W:0]  mem_req_addr,
  input logic [7:0]        mem_req_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r8_one_event: assert property (@(posedge clk) disable iff (rst)
    !(ev_frame && ev_buf));

  a_r4_halt_set: assert property (@(posedge clk) disable iff (rst)
    ptr_upd_valid |-> halt_status[31 - int'(ptr_upd_ring)]);

  a_r3_ptr_aligned: assert property (@(posedge clk) disable iff (rst)
    ptr_upd_valid |-> ptr_upd_addr[2:0] == 3'b000);

  a_r9_wb_flags_only: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_we |-> mem_req_addr[2:1] == 2'b00);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);
endmodule

bind txring_walker txring_walker_chk #(.NRINGS(NRINGS), .HI_W(HI_W)) u_chk (.*);

// File: tb/txring_walker_bench.sv
module txring_walker_bench;
  localparam int NR = 2;
  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic cfg_tx_en = 1'b1, cfg_le = 1'b0, cfg_pad_en = 1'b0;
  logic [3:0] cfg_addr_hi = 4'h0;
  logic [NR*32-1:0] ring_base = '0, ring_ptr = '0;
  logic kick = 1'b0;
  logic [0:0] kick_ring = '0;
  logic busy, ptr_upd_valid, ev_frame, ev_buf;
  logic [0:0] ptr_upd_ring;
  logic [31:0] ptr_upd_addr, halt_status;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [35:0] mem_req_addr;
  logic [7:0] mem_req_wdata, mem_rsp_data;
  logic tx_valid, tx_ready, tx_last;
  logic [7:0] tx_data;

  txring_walker u_txring_walker (.*);

  logic [7:0] mem [0:4095];
  logic [7:0] cap [0:255];
  int cyc, reqs, hi_bad, evf, evb, ptr_n, frames, done_len, cap_n;
  logic [31:0] last_ptr;
  logic [0:0] last_ring;
  logic bw_en = 1'b0;
  logic [11:0] bw_addr = '0;
  logic [7:0] bw_data = '0;
  int checks = 0, fails = 0;
  logic [31:0] kick_halt;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    tx_ready <= (cyc % 5) != 3;
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      reqs <= 0; hi_bad <= 0; evf <= 0; evb <= 0; ptr_n <= 0;
      frames <= 0; done_len <= 0; cap_n <= 0; last_ptr <= '0; last_ring <= '0;
    end else begin
      if (bw_en) mem[bw_addr] = bw_data;
      if (mem_req_valid && mem_req_ready) begin
        reqs <= reqs + 1;
        if (mem_req_addr[35:32] != cfg_addr_hi) hi_bad <= hi_bad + 1;
        if (mem_req_we) mem[mem_req_addr[11:0]] = mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[11:0]];
        end
      end
      if (tx_valid && tx_ready) begin
        cap[cap_n] <= tx_data;
        if (tx_last) begin
          frames <= frames + 1; done_len <= cap_n + 1; cap_n <= 0;
        end else cap_n <= cap_n + 1;
      end
      if (ev_frame) evf <= evf + 1;
      if (ev_buf) evb <= evb + 1;
      if (ptr_upd_valid) begin
        ptr_n <= ptr_n + 1; last_ptr <= ptr_upd_addr; last_ring <= ptr_upd_ring;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = 12'(a); bw_data = d;
  endtask

  task automatic put_desc(input int a, input logic le, input logic [15:0] fl,
                          input logic [15:0] ln, input logic [31:0] p);
    if (le) begin
      poke(a, fl[7:0]); poke(a+1, fl[15:8]); poke(a+2, ln[7:0]); poke(a+3, ln[15:8]);
      poke(a+4, p[7:0]); poke(a+5, p[15:8]); poke(a+6, p[23:16]); poke(a+7, p[31:24]);
    end else begin
      poke(a, fl[15:8]); poke(a+1, fl[7:0]); poke(a+2, ln[15:8]); poke(a+3, ln[7:0]);
      poke(a+4, p[31:24]); poke(a+5, p[23:16]); poke(a+6, p[15:8]); poke(a+7, p[7:0]);
    end
    @(negedge clk); bw_en = 1'b0;
  endtask

  function automatic logic [15:0] get_flags(input int a, input logic le);
    return le ? {mem[a+1], mem[a]} : {mem[a], mem[a+1]};
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic run_walk(input int r);
    int n = 0;
    @(negedge clk); kick_ring = 1'(r); kick = 1'b1;
    @(negedge clk); kick = 1'b0; kick_halt = halt_status;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) begin fails++; checks++; $display("FAIL R4 walk timeout actual=busy expected=idle"); end
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int f0, b0, e0, p0, r0, bad;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset tx_valid", tx_valid, 0);
    chk("reset mem_req_valid", mem_req_valid, 0);
    chk("reset halt_status", halt_status, 0);

    // R1: disabled transmit ignores kick
    cfg_tx_en = 1'b0; r0 = reqs; p0 = ptr_n;
    run_walk(0);
    chk("R1 no requests", reqs - r0, 0);
    chk("R1 no pointer report", ptr_n - p0, 0);
    cfg_tx_en = 1'b1;

    // R2 R3 R5 R6 R8 R9 R10: big-endian three-descriptor frame on ring 0
    cfg_le = 1'b0; cfg_pad_en = 1'b1;
    ring_base[31:0] = 32'h100; ring_ptr[31:0] = 32'h105;
    put_desc(32'h100, 0, 16'h9000, 16'd3, 32'h800);
    put_desc(32'h108, 0, 16'h8000, 16'd0, 32'h0);
    put_desc(32'h110, 0, 16'h9ED7, 16'd62, 32'h900);
    put_desc(32'h118, 0, 16'h0000, 16'd0, 32'h0);
    f0 = frames; b0 = evb; e0 = evf;
    run_walk(0);
    chk("R6 one frame", frames - f0, 1);
    chk("R5 R7 frame length 65 no pad", done_len, 65);
    bad = 0;
    for (int i = 0; i < 65; i++)
      if (cap[i] != (i < 3 ? pat(32'h800 + i) : pat(32'h900 + i - 3))) bad++;
    chk("R2 R5 gathered bytes", bad, 0);
    chk("R8 buffer event", evb - b0, 1);
    chk("R8 frame event", evf - e0, 1);
    chk("R9 writeback d0", get_flags(32'h100, 0), 16'h1000);
    chk("R9 writeback d1", get_flags(32'h108, 0), 16'h0000);
    chk("R9 writeback d2", get_flags(32'h110, 0), 16'h1C00);
    chk("R9 length kept", {mem[32'h112], mem[32'h113]}, 62);
    chk("R4 R10 stop address", last_ptr, 32'h118);
    chk("R4 halt bit ring0", halt_status, 32'h8000_0000);

    // R2 LE, R3 high bits and base masking, R7 first-desc pad, R10 wrap on ring 1
    cfg_le = 1'b1; cfg_pad_en = 1'b0; cfg_addr_hi = 4'hA;
    ring_base[63:32] = 32'h203; ring_ptr[63:32] = 32'h208;
    put_desc(32'h208, 1, 16'hE000, 16'd5, 32'hA00);
    put_desc(32'h200, 1, 16'h9800, 16'd10, 32'hA40);
    f0 = frames; e0 = evf;
    run_walk(1);
    chk("R7 padded length", done_len, 64);
    chk("R6 one frame ring1", frames - f0, 1);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (cap[i] != (i < 5 ? pat(32'hA00 + i) : i < 15 ? pat(32'hA40 + i - 5) : 8'h00)) bad++;
    chk("R7 pad bytes zero, R2 LE data", bad, 0);
    chk("R8 frame event ring1", evf - e0, 1);
    chk("R10 wrap stop address", last_ptr, 32'h208);
    chk("R4 ring reported", last_ring, 1);
    chk("R4 halt bits", halt_status, 32'hC000_0000);
    chk("R9 LE writeback", get_flags(32'h208, 1), 16'h6000);
    chk("R3 high address bits", hi_bad, 0);
    cfg_addr_hi = 4'h0;

    // R7 sweep over lengths with global pad enable toggled
    ring_ptr[31:0] = 32'h300; ring_base[31:0] = 32'h300;
    for (int L = 1; L <= 70; L++) begin
      logic pd, le;
      int E;
      pd = L[0]; le = (L % 3) == 0;
      cfg_pad_en = pd; cfg_le = le;
      put_desc(32'h300, le, 16'h8800, 16'(L), 32'hC00 + L);
      put_desc(32'h308, le, 16'h0000, 16'd0, 32'h0);
      f0 = frames;
      run_walk(0);
      E = (pd && L < 64) ? 64 : L;
      chk($sformatf("R7 sweep frames L=%0d", L), frames - f0, 1);
      chk($sformatf("R7 sweep length L=%0d", L), done_len, E);
      bad = 0;
      for (int i = 0; i < E; i++)
        if (cap[i] != (i < L ? pat(32'hC00 + L + i) : 8'h00)) bad++;
      chk($sformatf("R5 sweep data L=%0d", L), bad, 0);
      chk($sformatf("R10 sweep stop L=%0d", L), last_ptr, 32'h308);
    end

    // R6 frame carried across a halt; R7 later pad flag ignored; R4 halt clear
    cfg_le = 1'b0; cfg_pad_en = 1'b0;
    put_desc(32'h300, 0, 16'h8000, 16'd4, 32'hD00);
    put_desc(32'h308, 0, 16'h0000, 16'd0, 32'h0);
    f0 = frames;
    run_walk(0);
    chk("R6 no frame before last", frames - f0, 0);
    chk("R4 halt after partial", halt_status[31], 1);
    put_desc(32'h308, 0, 16'hC800, 16'd2, 32'hD80);
    put_desc(32'h310, 0, 16'h0000, 16'd0, 32'h0);
    ring_ptr[31:0] = 32'h308;
    run_walk(0);
    chk("R4 halt cleared on new walk", kick_halt[31], 0);
    chk("R6 frame across walks", frames - f0, 1);
    chk("R7 later pad flag ignored", done_len, 6);
    bad = 0;
    for (int i = 0; i < 6; i++)
      if (cap[i] != (i < 4 ? pat(32'hD00 + i) : pat(32'hD80 + i - 4))) bad++;
    chk("R6 carried bytes", bad, 0);

    // R8 last flag on an empty frame gives a buffer event only
    ring_ptr[31:0] = 32'h300;
    put_desc(32'h300, 0, 16'h9800, 16'd0, 32'h0);
    put_desc(32'h308, 0, 16'h0000, 16'd0, 32'h0);
    f0 = frames; b0 = evb; e0 = evf;
    run_walk(0);
    chk("R8 empty last buffer event", evb - b0, 1);
    chk("R8 empty last no frame event", evf - e0, 0);
    chk("R6 empty last no frame", frames - f0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule